// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why a microcontroller core last restarted or woke up. A one-cycle pulse arrives on one of nine event inputs: power-on, brown-out, reset instruction, configuration mismatch, external reset pin, watchdog time-out, interrupt wake, stack full and stack underflow. Each event applies its own set, clear or keep pattern to six cause flags and two stack flags. Several of these patterns depend on the power mode the core is in when the event arrives.

In the cycle after an event, the block also reports what the program counter should do. It can load zero, advance by two, or jump to one of two interrupt vectors. Software can write the flag byte. A write can set the cause flags back to 1 and can clear the stack flags, so the next cause can be told apart from the last one.

Top module: `rst_cause_reg`

## Requirements
- R1: `flags` bit order is [7] stack-full, [6] stack-underflow, [5] cfg-ok, [4] instr-ok, [3] wdt-ok, [2] awake, [1] por, [0] bor. `pc_act` codes are 0 none, 1 load zero, 2 advance by two, 3 load vector. Reset or a power-on event gives `flags` = 8'h3C. A power-on event also gives `pc_act` = 1 in the next cycle.
- R2: A reset-instruction event clears bit 4 only. A configuration-mismatch event clears bit 5 only. Both give `pc_act` = 1.
- R3: A brown-out event sets bits 5:2, clears bit 0, and keeps bits 1, 6 and 7. It gives `pc_act` = 1.
- R4: `pwr_mode` codes are 0 full power, 1 run, 2 idle, 3 sleep. An external-pin event sets bit 3 in run mode. In idle or sleep it sets bit 3 and clears bit 2. In full power it changes no flag. It always gives `pc_act` = 1.
- R5: A watchdog event clears bit 3. In full power or run it gives `pc_act` = 1. In idle or sleep it also clears bit 2 and gives `pc_act` = 2.
- R6: An interrupt-wake event in modes 1 to 3 clears bit 2 only. The PC action is then as follows:
  - with `gie_hi` set: vector 16'h0008;
  - else with `gie_lo` set: vector 16'h0018;
  - otherwise: `pc_act` = 2.
  In full power the wake has no effect. `pc_vec` is nonzero only together with `pc_act` = 3.
- R7: Stack full sets bit 7 and stack underflow sets bit 6. Either one gives `pc_act` = 1 when `stk_rst_en` is high, and `pc_act` = 0 when it is low.
- R8: When several events arrive in one cycle, only the highest applies. The order, highest first, is power-on, brown-out, external pin, watchdog, configuration mismatch, reset instruction, stack, interrupt wake.
- R9: A software write ORs `sw_wdata[5:0]` into bits 5:0 and ANDs `sw_wdata[7:6]` into bits 7:6. The write is dropped in any cycle in which an event takes effect.
- R10: In a cycle with no effective event and no write, all flags hold and `pc_act` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pwr_on | input | 1 | Power-on event |
| ev_brown | input | 1 | Brown-out event |
| ev_rst_instr | input | 1 | Reset instruction executed |
| ev_cfg_mis | input | 1 | Configuration mismatch |
| ev_ext_pin | input | 1 | External reset pin |
| ev_wdt | input | 1 | Watchdog time-out |
| ev_int_wake | input | 1 | Interrupt wake |
| ev_stk_full | input | 1 | Stack full |
| ev_stk_under | input | 1 | Stack underflow |
| pwr_mode | input | 2 | Power mode at the time of the event |
| stk_rst_en | input | 1 | Stack errors force a reset |
| gie_hi | input | 1 | High-priority interrupt enable |
| gie_lo | input | 1 | Low-priority interrupt enable |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| flags | output | 8 | Flag byte |
| pc_act | output | 2 | Program-counter action |
| pc_vec | output | 16 | Target address for a vector load |

## Verification
The flags are the block's only state, and they appear directly on `flags`. A wrong set, clear or keep therefore shows one cycle after the event that caused it. Because flags persist, a mistake that hits a flag the event should have left alone also stays visible in later cycles, until a later event or write overwrites it. A wrong priority or mode decode shows up one cycle later as a wrong `pc_act` or `pc_vec` pulse. The bench sweeps every single event across all modes, enables and interrupt-enable settings, and every combination of simultaneous events, checking each against a model built from the requirements.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter logic [15:0] VEC_HI = 16'h0008,
  parameter logic [15:0] VEC_LO = 16'h0018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_pwr_on,
  input  logic        ev_brown,
  input  logic        ev_rst_instr,
  input  logic        ev_cfg_mis,
  input  logic        ev_ext_pin,
  input  logic        ev_wdt,
  input  logic        ev_int_wake,
  input  logic        ev_stk_full,
  input  logic        ev_stk_under,
  input  logic [1:0]  pwr_mode,
  input  logic        stk_rst_en,
  input  logic        gie_hi,
  input  logic        gie_lo,
  input  logic        sw_we,
  input  logic [7:0]  sw_wdata,
  output logic [7:0]  flags,
  output logic [1:0]  pc_act,
  output logic [15:0] pc_vec
);
  localparam int B_BOR = 0, B_POR = 1, B_PD = 2, B_TO = 3, B_RI = 4, B_CM = 5, B_SUN = 6, B_SFL = 7;
  localparam logic [7:0] PWRON_FLAGS = 8'h3C;
  localparam logic [1:0] ACT_NONE = 2'd0, ACT_ZERO = 2'd1, ACT_ADV = 2'd2, ACT_VEC = 2'd3;

  logic [7:0]  flg, flg_nx;
  logic [1:0]  act, act_nx;
  logic [15:0] vec, vec_nx;

  wire managed = pwr_mode != 2'd0;
  wire low_pwr = pwr_mode[1];
  wire stk_ev  = ev_stk_full | ev_stk_under;

  always_comb begin
    flg_nx = flg;
    act_nx = ACT_NONE;
    vec_nx = '0;
    if (ev_pwr_on) begin
      flg_nx = PWRON_FLAGS;
      act_nx = ACT_ZERO;
    end else if (ev_brown) begin
      flg_nx[B_CM:B_PD] = 4'hF;
      flg_nx[B_BOR] = 1'b0;
      act_nx = ACT_ZERO;
    end else if (ev_ext_pin) begin
      if (managed) flg_nx[B_TO] = 1'b1;
      if (low_pwr) flg_nx[B_PD] = 1'b0;
      act_nx = ACT_ZERO;
    end else if (ev_wdt) begin
      flg_nx[B_TO] = 1'b0;
      if (low_pwr) begin
        flg_nx[B_PD] = 1'b0;
        act_nx = ACT_ADV;
      end else begin
        act_nx = ACT_ZERO;
      end
    end else if (ev_cfg_mis) begin
      flg_nx[B_CM] = 1'b0;
      act_nx = ACT_ZERO;
    end else if (ev_rst_instr) begin
      flg_nx[B_RI] = 1'b0;
      act_nx = ACT_ZERO;
    end else if (stk_ev) begin
      if (ev_stk_full)  flg_nx[B_SFL] = 1'b1;
      if (ev_stk_under) flg_nx[B_SUN] = 1'b1;
      if (stk_rst_en)   act_nx = ACT_ZERO;
    end else if (ev_int_wake && managed) begin
      flg_nx[B_PD] = 1'b0;
      if (gie_hi) begin
        act_nx = ACT_VEC;
        vec_nx = VEC_HI;
      end else if (gie_lo) begin
        act_nx = ACT_VEC;
        vec_nx = VEC_LO;
      end else begin
        act_nx = ACT_ADV;
      end
    end else if (sw_we) begin
      flg_nx[B_CM:B_BOR]  = flg[B_CM:B_BOR] | sw_wdata[B_CM:B_BOR];
      flg_nx[B_SFL:B_SUN] = flg[B_SFL:B_SUN] & sw_wdata[B_SFL:B_SUN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg <= PWRON_FLAGS;
      act <= ACT_NONE;
      vec <= '0;
    end else begin
      flg <= flg_nx;
      act <= act_nx;
      vec <= vec_nx;
    end
  end

  assign flags  = flg;
  assign pc_act = act;
  assign pc_vec = vec;
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_pwr_on,
  input logic        ev_brown,
  input logic        ev_rst_instr,
  input logic        ev_cfg_mis,
  input logic        ev_ext_pin,
  input logic        ev_wdt,
  input logic        ev_int_wake,
  input logic        ev_stk_full,
  input logic        ev_stk_under,
  input logic [1:0]  pwr_mode,
  input logic        sw_we,
  input logic [7:0]  flags,
  input logic [1:0]  pc_act,
  input logic [15:0] pc_vec
);
  wire any_ev = ev_pwr_on | ev_brown | ev_rst_instr | ev_cfg_mis | ev_ext_pin | ev_wdt
              | ev_stk_full | ev_stk_under | (ev_int_wake && pwr_mode != 2'd0);

  AST_PWRON_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwr_on |=> flags == 8'h3C && pc_act == 2'd1); // R1
  AST_BROWN_KEEPS_POR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brown && !ev_pwr_on) |=> flags[1] == $past(flags[1]) && flags[0] == 1'b0
                                 && flags[5:2] == 4'hF && pc_act == 2'd1); // R3
  AST_WDT_LOWPWR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt && !ev_pwr_on && !ev_brown && !ev_ext_pin && pwr_mode[1])
      |=> pc_act == 2'd2 && flags[3:2] == 2'b00); // R5
  AST_VEC_ONLY_WITH_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    pc_vec != 16'h0 |-> pc_act == 2'd3); // R6
  AST_STACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[7] && !sw_we && !ev_pwr_on) |=> flags[7]); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ev && !sw_we) |=> $stable(flags) && pc_act == 2'd0); // R10
endmodule

bind rst_cause_reg rst_cause_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ev_pwr_on(ev_pwr_on), .ev_brown(ev_brown),
  .ev_rst_instr(ev_rst_instr), .ev_cfg_mis(ev_cfg_mis), .ev_ext_pin(ev_ext_pin),
  .ev_wdt(ev_wdt), .ev_int_wake(ev_int_wake), .ev_stk_full(ev_stk_full),
  .ev_stk_under(ev_stk_under), .pwr_mode(pwr_mode), .sw_we(sw_we),
  .flags(flags), .pc_act(pc_act), .pc_vec(pc_vec)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] ev = '0;
  logic [1:0] pwr_mode = '0;
  logic stk_rst_en = 1'b0, gie_hi = 1'b0, gie_lo = 1'b0, sw_we = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic [7:0] flags;
  logic [1:0] pc_act;
  logic [15:0] pc_vec;

  int checks = 0;
  int errors = 0;
  logic [7:0] ef = 8'h3C;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg uut (
    .clk(clk), .rst_n(rst_n),
    .ev_pwr_on(ev[0]), .ev_brown(ev[1]), .ev_ext_pin(ev[2]), .ev_wdt(ev[3]),
    .ev_cfg_mis(ev[4]), .ev_rst_instr(ev[5]), .ev_stk_full(ev[6]), .ev_stk_under(ev[7]),
    .ev_int_wake(ev[8]), .pwr_mode(pwr_mode), .stk_rst_en(stk_rst_en),
    .gie_hi(gie_hi), .gie_lo(gie_lo), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .flags(flags), .pc_act(pc_act), .pc_vec(pc_vec)
  );

  task automatic check(input string req, input logic [7:0] xf, input logic [1:0] xa, input logic [15:0] xv);
    checks++;
    if (flags !== xf || pc_act !== xa || pc_vec !== xv) begin
      errors++;
      $display("FAIL %s: flags=%h act=%0d vec=%h expected flags=%h act=%0d vec=%h",
               req, flags, pc_act, pc_vec, xf, xa, xv);
    end
  endtask

  task automatic step(input logic [8:0] e, input logic [1:0] m, input logic en,
                      input logic [1:0] g, input logic we, input logic [7:0] wd, input string force_req);
    logic [7:0] nf;
    logic [1:0] na;
    logic [15:0] nv;
    string req;
    ev = e; pwr_mode = m; stk_rst_en = en; gie_hi = g[1]; gie_lo = g[0];
    sw_we = we; sw_wdata = wd;
    nf = ef; na = 2'd0; nv = 16'h0; req = "R10";
    if (e[0]) begin nf = 8'h3C; na = 2'd1; req = "R1"; end
    else if (e[1]) begin nf = {ef[7:6], 4'hF, ef[1], 1'b0}; na = 2'd1; req = "R3"; end
    else if (e[2]) begin
      if (m != 2'd0) nf[3] = 1'b1;
      if (m >= 2'd2) nf[2] = 1'b0;
      na = 2'd1; req = "R4";
    end else if (e[3]) begin
      nf[3] = 1'b0;
      if (m >= 2'd2) begin nf[2] = 1'b0; na = 2'd2; end else na = 2'd1;
      req = "R5";
    end else if (e[4]) begin nf[5] = 1'b0; na = 2'd1; req = "R2"; end
    else if (e[5]) begin nf[4] = 1'b0; na = 2'd1; req = "R2"; end
    else if (e[6] || e[7]) begin
      if (e[6]) nf[7] = 1'b1;
      if (e[7]) nf[6] = 1'b1;
      na = en ? 2'd1 : 2'd0; req = "R7";
    end else if (e[8] && m != 2'd0) begin
      nf[2] = 1'b0; req = "R6";
      if (g[1]) begin na = 2'd3; nv = 16'h0008; end
      else if (g[0]) begin na = 2'd3; nv = 16'h0018; end
      else na = 2'd2;
    end else if (we) begin
      nf = {ef[7:6] & wd[7:6], ef[5:0] | wd[5:0]}; req = "R9";
    end
    if (force_req != "") req = force_req;
    @(negedge clk);
    ef = nf;
    check(req, nf, na, nv);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h3C, 2'd0, 16'h0);
    for (int e = 0; e < 9; e++)
      for (int m = 0; m < 4; m++)
        for (int en = 0; en < 2; en++)
          for (int g = 0; g < 4; g++) begin
            step(9'h0, 2'(m), 1'b0, 2'b00, 1'b1, 8'(e*37 + m*11 + g*5 + en), "");
            step(9'(1 << e), 2'(m), en[0], 2'(g), 1'b0, 8'h00, "");
            step(9'h0, 2'(m), 1'b0, 2'b00, 1'b0, 8'h00, "R10");
          end
    for (int v = 1; v < 512; v++) begin
      step(9'(v), 2'(v[5:4] ^ v[1:0]), v[6], 2'(v[8:7]), v[2], 8'(v*3), "R8");
      step(9'h0, 2'(v), 1'b0, 2'b00, 1'b1, 8'(v*7), "R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule